// File: doc/BRIEF.md
# Wide-Bus UART FIFO Access Port

This block sits between a 32-bit register bus and the byte-wide FIFOs of one UART channel. It lets software move up to four bytes per bus word, so that fewer bus cycles are spent per byte. Two address windows are decoded relative to a base parameter. The lower window serves two purposes. A read from it pops received bytes and packs them one per byte lane. A write to it pushes transmit bytes one per enabled lane. The upper window is read-only and returns received bytes interleaved with their line-status bytes. One word holds two such pairs, so a driver can collect data and error flags together in a single burst.

The receive side is fed by a deserializer through a push strobe that carries a data byte and a status byte. The transmit side is emptied by a serializer through a pop strobe. Both FIFOs are 64 entries deep by default. A read that asks for more entries than are held returns zero in the lanes it could not fill and sets a sticky underflow flag. A write that finds the transmit FIFO full drops the surplus bytes and sets a sticky overflow flag. If a read and a write are asserted in the same cycle, the write is ignored.

Top module: `uart_wide_port`

## Requirements
- R1: A read of the data window (BASE to BASE+0x7F) pops one receive entry for each asserted byte enable. The entries are placed in ascending lane order, so with all four enables the oldest byte lands in bits 7:0 and the newest in bits 31:24.
- R2: A read of the status window (BASE+0x80 to BASE+0xFF) with all four enables pops two entries. The older entry goes in bits 15:0 and the newer in bits 31:16. Each half carries the status byte in its low byte and the data byte in its high byte.
- R3: In the status window, each 16-bit half (enables 1:0 or 3:2) is served only if both of its enables are asserted. A half served alone pops one entry into that half. A half with only one enable asserted returns zero and pops nothing.
- R4: If the receive FIFO holds fewer entries than a read requests, the unfilled lanes read zero and only the held entries are popped. `rxUnderflow` is then set and stays set until reset.
- R5: A write to the data window pushes the bytes of the enabled lanes into the transmit FIFO in ascending lane order. The serializer then sees them on `txData` in that order.
- R6: The transmit FIFO holds 64 bytes, and 16 full-word writes fill it without overflow. Any byte pushed while it is full is dropped, and `txOverflow` is set and stays set until reset.
- R7: A write to the status window, or any access outside the two windows, changes neither FIFO. A read outside the windows returns zero.
- R8: A receive push that arrives while 64 entries are held is dropped, and the held entries are unchanged.
- R9: Read data appears on `busRdata` in the cycle after `busRd` is sampled. It holds until the next read.
- R10: After reset both FIFOs are empty, `txValid` is low, both flags are clear and `busRdata` is zero.
- R11: The windows are decoded from the address bits above bit 7 against the BASE parameter (default 0x100). Any word address inside a window behaves like its first word, so a 32-word burst over the status window drains a full receive FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 10 | Byte address of the access |
| busRd | input | 1 | Read strobe, one cycle per word |
| busWr | input | 1 | Write strobe, one cycle per word |
| busBe | input | 4 | Byte enables, bit k for bits 8k+7:8k |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Registered read data |
| rxPush | input | 1 | Deserializer push strobe |
| rxData | input | 8 | Received data byte |
| rxStat | input | 8 | Line-status byte of the received byte |
| txPop | input | 1 | Serializer pop strobe |
| txData | output | 8 | Oldest transmit byte |
| txValid | output | 1 | Transmit FIFO not empty |
| rxUnderflow | output | 1 | Sticky: a read found too few entries |
| txOverflow | output | 1 | Sticky: a transmit byte was dropped |

## Verification
A read pointer or fill count that has gone wrong shows up at the ports on the very next read. Bytes arrive shifted or repeated across lanes, or zero lanes appear where data was expected, and a false or missing `rxUnderflow` appears in the same cycle. A bad transmit pointer is seen when the serializer drains the FIFO, as a byte order on `txData` that does not match the order written. A wrong free count is seen as `txOverflow` rising early or late around the 64-byte boundary. A random mix of pushes, reads, writes and drains is compared with a queue model, so each of these faults is caught within a few operations.

// File: rtl/uwp_pkg.sv
package uwp_pkg;
  localparam int LANES = 4;
  localparam int BUS_W = 8 * LANES;

  typedef enum logic [1:0] {
    WIN_NONE = 2'd0,
    WIN_DATA = 2'd1,
    WIN_STAT = 2'd2
  } win_e;

  // strobes from control to the FIFO datapath
  typedef struct packed {
    logic [2:0] rxPopN;   // entries to remove from the receive FIFO
    logic [2:0] txPushN;  // packed bytes to append to the transmit FIFO
  } fifoCmd_t;
endpackage

// File: rtl/uwp_fifos.sv
module uwp_fifos
  import uwp_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  fifoCmd_t               cmd,
  input  logic [BUS_W-1:0]       txPushData,
  input  logic                   rxPush,
  input  logic [7:0]             rxData,
  input  logic [7:0]             rxStat,
  input  logic                   txPop,
  output logic [CNT_W-1:0]       rxCount,
  output logic [CNT_W-1:0]       txCount,
  output logic [LANES-1:0][7:0]  peekData,
  output logic [LANES-1:0][7:0]  peekStat,
  output logic [7:0]             txData,
  output logic                   txValid
);
  logic [7:0] rxDataMem [DEPTH];
  logic [7:0] rxStatMem [DEPTH];
  logic [7:0] txMem [DEPTH];
  logic [PTR_W-1:0] rxWrPtr, rxRdPtr, txWrPtr, txRdPtr;
  logic rxAccept, txTake;

  assign rxAccept = rxPush && (rxCount != CNT_W'(DEPTH));
  assign txTake   = txPop && (txCount != '0);

  // receive storage
  always_ff @(posedge clk) begin
    if (rxAccept) begin
      rxDataMem[rxWrPtr] <= rxData;
      rxStatMem[rxWrPtr] <= rxStat;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxWrPtr <= '0;
      rxRdPtr <= '0;
      rxCount <= '0;
    end else begin
      if (rxAccept) rxWrPtr <= rxWrPtr + 1'b1;
      rxRdPtr <= rxRdPtr + PTR_W'(cmd.rxPopN);
      rxCount <= rxCount + CNT_W'(rxAccept) - CNT_W'(cmd.rxPopN);
    end
  end

  always_comb begin
    for (int j = 0; j < LANES; j++) begin
      peekData[j] = rxDataMem[rxRdPtr + PTR_W'(j)];
      peekStat[j] = rxStatMem[rxRdPtr + PTR_W'(j)];
    end
  end

  // transmit storage: bytes arrive already packed in push order
  always_ff @(posedge clk) begin
    for (int j = 0; j < LANES; j++) begin
      if (3'(j) < cmd.txPushN) txMem[txWrPtr + PTR_W'(j)] <= txPushData[8*j +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txWrPtr <= '0;
      txRdPtr <= '0;
      txCount <= '0;
    end else begin
      txWrPtr <= txWrPtr + PTR_W'(cmd.txPushN);
      if (txTake) txRdPtr <= txRdPtr + 1'b1;
      txCount <= txCount + CNT_W'(cmd.txPushN) - CNT_W'(txTake);
    end
  end

  assign txData  = txMem[txRdPtr];
  assign txValid = (txCount != '0);

  // control must never pop entries that are not held
  assert_pop_within_fill_R4: assert property (@(posedge clk) disable iff (!rstN)
    CNT_W'(cmd.rxPopN) <= rxCount);

  // control must never push past the free room
  assert_push_within_room_R6: assert property (@(posedge clk) disable iff (!rstN)
    (txCount + CNT_W'(cmd.txPushN)) <= CNT_W'(DEPTH));

  // a push into a full receive FIFO leaves it full and unchanged in size
  assert_full_push_dropped_R8: assert property (@(posedge clk) disable iff (!rstN)
    (rxPush && rxCount == CNT_W'(DEPTH) && cmd.rxPopN == 3'd0) |=> rxCount == CNT_W'(DEPTH));

  // without deserializer pushes the fill drops by exactly the popped count
  assert_fill_tracks_pops_R1: assert property (@(posedge clk) disable iff (!rstN)
    !rxPush |=> rxCount == $past(rxCount) - CNT_W'($past(cmd.rxPopN)));
endmodule

// File: rtl/uwp_ctrl.sv
module uwp_ctrl
  import uwp_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter logic [ADDR_W-1:0] BASE = 10'h100,
  parameter int DEPTH = 64,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [ADDR_W-1:0]      busAddr,
  input  logic                   busRd,
  input  logic                   busWr,
  input  logic [LANES-1:0]       busBe,
  input  logic [BUS_W-1:0]       busWdata,
  input  logic [CNT_W-1:0]       rxCount,
  input  logic [CNT_W-1:0]       txCount,
  input  logic [LANES-1:0][7:0]  peekData,
  input  logic [LANES-1:0][7:0]  peekStat,
  output fifoCmd_t               cmd,
  output logic [BUS_W-1:0]       txPushData,
  output logic [BUS_W-1:0]       busRdata,
  output logic                   rxUnderflow,
  output logic                   txOverflow
);
  win_e winKind;
  logic hitBlock, doWr;
  logic [2:0] laneOrd [LANES];
  logic [2:0] laneReq, halfReq, rxAvail, txAvail;
  logic [1:0] halfEn;
  logic [2:0] halfOrd [2];
  logic [CNT_W-1:0] freeSlots;
  logic [BUS_W-1:0] rdNext;
  logic rdShort, wrDrop;
  logic unusedAddrBits;

  assign unusedAddrBits = ^busAddr[6:0];
  assign hitBlock = (busAddr[ADDR_W-1:8] == BASE[ADDR_W-1:8]);
  assign winKind  = !hitBlock ? WIN_NONE : (busAddr[7] ? WIN_STAT : WIN_DATA);
  assign doWr     = busWr && !busRd;

  // rank of each enabled lane among the enabled lanes
  always_comb begin
    int ord;
    ord = 0;
    for (int k = 0; k < LANES; k++) begin
      laneOrd[k] = 3'(ord);
      if (busBe[k]) ord++;
    end
    laneReq = 3'(ord);
  end

  // status window works on whole 16-bit halves
  assign halfEn[0]  = busBe[1] & busBe[0];
  assign halfEn[1]  = busBe[3] & busBe[2];
  assign halfOrd[0] = 3'd0;
  assign halfOrd[1] = {2'b00, halfEn[0]};
  assign halfReq    = {2'b00, halfEn[0]} + {2'b00, halfEn[1]};

  assign rxAvail   = (rxCount >= CNT_W'(LANES)) ? 3'(LANES) : rxCount[2:0];
  assign freeSlots = CNT_W'(DEPTH) - txCount;
  assign txAvail   = (freeSlots >= CNT_W'(LANES)) ? 3'(LANES) : freeSlots[2:0];

  // read assembly and pop count
  always_comb begin
    rdNext     = '0;
    cmd.rxPopN = 3'd0;
    rdShort    = 1'b0;
    if (busRd && winKind == WIN_DATA) begin
      for (int k = 0; k < LANES; k++) begin
        if (busBe[k] && laneOrd[k] < rxAvail) rdNext[8*k +: 8] = peekData[laneOrd[k][1:0]];
      end
      cmd.rxPopN = (laneReq < rxAvail) ? laneReq : rxAvail;
      rdShort    = laneReq > rxAvail;
    end else if (busRd && winKind == WIN_STAT) begin
      for (int h = 0; h < 2; h++) begin
        if (halfEn[h] && halfOrd[h] < rxAvail)
          rdNext[16*h +: 16] = {peekData[halfOrd[h][1:0]], peekStat[halfOrd[h][1:0]]};
      end
      cmd.rxPopN = (halfReq < rxAvail) ? halfReq : rxAvail;
      rdShort    = halfReq > rxAvail;
    end
  end

  // write packing and push count
  always_comb begin
    txPushData  = '0;
    cmd.txPushN = 3'd0;
    wrDrop      = 1'b0;
    if (doWr && winKind == WIN_DATA) begin
      for (int k = 0; k < LANES; k++) begin
        if (busBe[k] && laneOrd[k] < txAvail)
          txPushData[{laneOrd[k][1:0], 3'b000} +: 8] = busWdata[8*k +: 8];
      end
      cmd.txPushN = (laneReq < txAvail) ? laneReq : txAvail;
      wrDrop      = laneReq > txAvail;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busRdata    <= '0;
      rxUnderflow <= 1'b0;
      txOverflow  <= 1'b0;
    end else begin
      if (busRd) busRdata <= rdNext;
      if (rdShort) rxUnderflow <= 1'b1;
      if (wrDrop) txOverflow <= 1'b1;
    end
  end

  assert_underflow_sticky_R4: assert property (@(posedge clk) disable iff (!rstN)
    rxUnderflow |=> rxUnderflow);

  assert_overflow_sticky_R6: assert property (@(posedge clk) disable iff (!rstN)
    txOverflow |=> txOverflow);

  assert_outside_reads_zero_R7: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && busAddr[ADDR_W-1:8] != BASE[ADDR_W-1:8]) |=> busRdata == '0);

  assert_rdata_holds_R9: assert property (@(posedge clk) disable iff (!rstN)
    !busRd |=> $stable(busRdata));

  assert_status_write_inert_R7: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr[7]) |-> cmd.txPushN == 3'd0);
endmodule

// File: rtl/uart_wide_port.sv
module uart_wide_port
  import uwp_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter logic [ADDR_W-1:0] BASE = 10'h100,
  parameter int DEPTH = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRd,
  input  logic              busWr,
  input  logic [3:0]        busBe,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  input  logic              rxPush,
  input  logic [7:0]        rxData,
  input  logic [7:0]        rxStat,
  input  logic              txPop,
  output logic [7:0]        txData,
  output logic              txValid,
  output logic              rxUnderflow,
  output logic              txOverflow
);
  localparam int CNT_W = $clog2(DEPTH) + 1;

  fifoCmd_t cmd;
  logic [BUS_W-1:0] txPushData;
  logic [CNT_W-1:0] rxCount, txCount;
  logic [LANES-1:0][7:0] peekData, peekStat;

  uwp_ctrl #(.ADDR_W(ADDR_W), .BASE(BASE), .DEPTH(DEPTH)) uCtrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busRd(busRd), .busWr(busWr),
    .busBe(busBe), .busWdata(busWdata), .rxCount(rxCount), .txCount(txCount),
    .peekData(peekData), .peekStat(peekStat), .cmd(cmd), .txPushData(txPushData),
    .busRdata(busRdata), .rxUnderflow(rxUnderflow), .txOverflow(txOverflow)
  );

  uwp_fifos #(.DEPTH(DEPTH)) uFifos (
    .clk(clk), .rstN(rstN), .cmd(cmd), .txPushData(txPushData),
    .rxPush(rxPush), .rxData(rxData), .rxStat(rxStat), .txPop(txPop),
    .rxCount(rxCount), .txCount(txCount), .peekData(peekData), .peekStat(peekStat),
    .txData(txData), .txValid(txValid)
  );
endmodule

// File: tb/tb_uart_wide_port.sv
`timescale 1ns/1ps
module tb_uart_wide_port;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [9:0] busAddr = '0;
  logic busRd = 1'b0, busWr = 1'b0;
  logic [3:0] busBe = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic rxPush = 1'b0;
  logic [7:0] rxData = '0, rxStat = '0;
  logic txPop = 1'b0;
  logic [7:0] txData;
  logic txValid, rxUnderflow, txOverflow;

  int checks = 0;
  int errors = 0;
  logic [15:0] rxQ[$];   // {status, data}
  logic [7:0]  txQ[$];
  bit expUf = 0, expOf = 0;

  always #10 clk = ~clk;

  uart_wide_port dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busRd(busRd), .busWr(busWr),
    .busBe(busBe), .busWdata(busWdata), .busRdata(busRdata), .rxPush(rxPush),
    .rxData(rxData), .rxStat(rxStat), .txPop(txPop), .txData(txData),
    .txValid(txValid), .rxUnderflow(rxUnderflow), .txOverflow(txOverflow)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit inData(input logic [9:0] a);
    return a[9:7] == 3'b010;
  endfunction
  function automatic bit inStat(input logic [9:0] a);
    return a[9:7] == 3'b011;
  endfunction

  task automatic rxInject(input logic [7:0] d, input logic [7:0] s);
    if (rxQ.size() < 64) rxQ.push_back({s, d});
    rxData = d; rxStat = s; rxPush = 1'b1;
    @(negedge clk);
    rxPush = 1'b0;
  endtask

  task automatic doRead(input logic [9:0] a, input logic [3:0] be, input string req);
    logic [31:0] exp;
    logic [15:0] e;
    exp = '0;
    if (inData(a)) begin
      for (int k = 0; k < 4; k++) if (be[k]) begin
        if (rxQ.size() > 0) begin e = rxQ.pop_front(); exp[8*k +: 8] = e[7:0]; end
        else expUf = 1;
      end
    end else if (inStat(a)) begin
      for (int h = 0; h < 2; h++) if (be[2*h] && be[2*h+1]) begin
        if (rxQ.size() > 0) begin e = rxQ.pop_front(); exp[16*h +: 16] = {e[7:0], e[15:8]}; end
        else expUf = 1;
      end
    end
    busAddr = a; busBe = be; busRd = 1'b1;
    @(negedge clk);
    busRd = 1'b0;
    check(busRdata == exp, req, busRdata, exp);
    check(rxUnderflow == expUf, {req, " underflow flag"}, 32'(rxUnderflow), 32'(expUf));
  endtask

  task automatic doWrite(input logic [9:0] a, input logic [3:0] be, input logic [31:0] d, input string req);
    if (inData(a)) begin
      for (int k = 0; k < 4; k++) if (be[k]) begin
        if (txQ.size() < 64) txQ.push_back(d[8*k +: 8]);
        else expOf = 1;
      end
    end
    busAddr = a; busBe = be; busWdata = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
    check(txOverflow == expOf, {req, " overflow flag"}, 32'(txOverflow), 32'(expOf));
  endtask

  task automatic drainTx(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      check(txValid == (txQ.size() != 0), {req, " txValid"}, 32'(txValid), 32'(txQ.size() != 0));
      if (txQ.size() == 0) break;
      check(txData == txQ[0], {req, " txData"}, 32'(txData), 32'(txQ[0]));
      void'(txQ.pop_front());
      txPop = 1'b1;
      @(negedge clk);
      txPop = 1'b0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int seedSet;
    logic [31:0] held;
    seedSet = $urandom(32'h5eed_1234);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10 reset state
    check(busRdata == 0, "R10 rdata", busRdata, 0);
    check(txValid == 0, "R10 txValid", 32'(txValid), 0);
    check(rxUnderflow == 0 && txOverflow == 0, "R10 flags", {30'd0, rxUnderflow, txOverflow}, 0);

    // R1 data window
    for (int i = 0; i < 6; i++) rxInject(8'h10 + 8'(i), 8'hA0 + 8'(i));
    doRead(10'h100, 4'b1111, "R1 full word");
    doRead(10'h104, 4'b0101, "R1 sparse lanes");

    // R2 / R3 status window
    for (int i = 0; i < 5; i++) rxInject(8'h40 + 8'(i), 8'h01 << i);
    doRead(10'h180, 4'b1111, "R2 pair word");
    doRead(10'h184, 4'b1100, "R3 upper half");
    doRead(10'h188, 4'b0001, "R3 partial half");
    doRead(10'h18C, 4'b0011, "R3 lower half");

    // R9 hold
    held = busRdata;
    repeat (3) @(negedge clk);
    check(busRdata == held, "R9 hold", busRdata, held);

    // R4 shortage
    doRead(10'h180, 4'b1111, "R4 short status");
    doRead(10'h100, 4'b1111, "R4 empty data");
    repeat (2) @(negedge clk);
    check(rxUnderflow == 1, "R4 sticky", 32'(rxUnderflow), 1);

    // R7 inert accesses
    rxInject(8'h77, 8'h02);
    rxInject(8'h78, 8'h03);
    doWrite(10'h180, 4'b1111, 32'hDEADBEEF, "R7 status write");
    doWrite(10'h300, 4'b1111, 32'hCAFEF00D, "R7 outside write");
    doRead(10'h300, 4'b1111, "R7 outside read");
    doRead(10'h000, 4'b1111, "R7 low outside read");
    drainTx(2, "R7 tx empty");
    doRead(10'h17C, 4'b0011, "R7 R11 rx intact");

    // R5 lane order
    doWrite(10'h100, 4'b1011, 32'h44332211, "R5 sparse write");
    doWrite(10'h104, 4'b1111, 32'h88776655, "R5 full write");
    drainTx(8, "R5 order");

    // R6 fill and overflow
    for (int i = 0; i < 16; i++) doWrite(10'h100 + 10'(4 * i), 4'b1111, $urandom, "R6 fill");
    check(txOverflow == 0, "R6 exact fill", 32'(txOverflow), 0);
    doWrite(10'h100, 4'b0110, 32'h12345678, "R6 overflow");
    check(txOverflow == 1, "R6 sticky", 32'(txOverflow), 1);
    drainTx(70, "R6 drain");

    // R8 full receive FIFO, R11 status burst
    for (int i = 0; i < 70; i++) rxInject(8'($urandom), 8'($urandom));
    for (int i = 0; i < 32; i++) doRead(10'h180 + 10'(4 * i), 4'b1111, "R8 R11 burst");
    doRead(10'h100, 4'b1111, "R8 emptied");

    // random mix
    for (int it = 0; it < 400; it++) begin
      logic [9:0] a;
      case ($urandom % 4)
        0: a = 10'h100 + 10'(4 * ($urandom % 32));
        1: a = 10'h180 + 10'(4 * ($urandom % 32));
        2: a = 10'h300;
        default: a = 10'h004;
      endcase
      case ($urandom % 4)
        0: for (int j = 0; j < 1 + int'($urandom % 4); j++) rxInject(8'($urandom), 8'($urandom));
        1: doRead(a, 4'($urandom), "R1 R2 R3 random read");
        2: doWrite(a, 4'($urandom), $urandom, "R5 random write");
        default: drainTx(1 + int'($urandom % 4), "R5 random drain");
      endcase
    end
    drainTx(70, "R5 final drain");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule